// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shift engine of an SPI master. It pulls parallel words from an external transmit FIFO and shifts them out on MOSI. At the same time it samples MISO and pushes each completed received word into an external receive FIFO. It generates SCLK from the system clock with an even divisor, and it drives an active-low slave select.

Static configuration inputs select:
- the word length, SCLK phase and polarity, and bit order;
- the direction of transfer;
- whether slave select stays low or pulses high between consecutive words;
- the slave-select lead time before the first SCLK edge;
- a delay of a few system clocks on the MISO capture point, to absorb slow return paths.

A transfer starts as soon as the transmit FIFO holds a word. Each word is one frame. Slave select is released when the transmit FIFO is found empty at a frame boundary. A five-bit status output combines the engine's busy indication with the four FIFO level flags. A sticky flag records a received frame that was lost because the receive FIFO was full.

Top module: `spi_frame_engine`

## Requirements
- R1: `frame_size` sets the frame length: 0 gives 4 bits, 1 gives 8 bits, and 2 or 3 give 16 bits. Frame data sits in the low bits of `tx_data` and `rx_data`, and the unused upper bits of `rx_data` are zero.
- R2: Whenever busy (`status[0]`) is low, `sclk` equals `cpol`. Each frame has exactly two SCLK edges per bit and ends with `sclk` back at `cpol`.
- R3: With `cpha`=0, the first bit is on MOSI before the first SCLK edge, data are captured on odd edges (1, 3, ...), and MOSI changes on even edges. With `cpha`=1, MOSI changes on odd edges from edge 3 onward, and data are captured on even edges.
- R4: `lsb_first`=0 shifts the most significant frame bit first, and `lsb_first`=1 shifts the least significant bit first. The setting applies to both MOSI and MISO.
- R5: `xfer_mode` 0 (and 3) transmits and receives. Mode 1 transmits only: no word is pushed and no overflow is recorded. Mode 2 receives only: MOSI is held at 0. In every mode each frame consumes one transmit FIFO entry.
- R6: With H = `baud_div`/2 system clocks, `ss_mode` controls slave select between back-to-back frames. Mode 0 (and 3) keeps `ss_n` low. Mode 1 drives it high for H cycles, and mode 2 drives it high for 2H cycles.
- R7: After each falling edge of `ss_n`, the first SCLK edge follows H cycles later when `ss_lead`=0, or 2H cycles later when `ss_lead`=1.
- R8: MISO is captured `rx_delay` (0 to 3) system clocks after the internal sampling edge. A frame does not complete, and busy does not drop, until its last bit has been captured.
- R9: `status` is {`rx_full`, `rx_empty`, `tx_empty`, `tx_full`, busy}, with busy at bit 0, TX full at bit 1, TX empty at bit 2, RX empty at bit 3 and RX full at bit 4.
- R10: Busy rises after the first pop and stays high while `ss_n` is low. When the transmit FIFO is empty at a frame boundary, `ss_n` goes high and busy drops.
- R11: A completed receive frame raises `rx_push` for one cycle only if `rx_full` was low when its last bit was captured. Otherwise the frame is dropped and `rx_overflow` is set, and it stays set until reset.
- R12: `tx_pop` is asserted only while `tx_empty` is low, never on two consecutive cycles, and exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Even SCLK divisor, at least 2 |
| frame_size | input | 2 | Frame length code |
| cpha | input | 1 | SCLK phase |
| cpol | input | 1 | SCLK idle level |
| lsb_first | input | 1 | Bit order |
| xfer_mode | input | 2 | Transfer direction |
| ss_mode | input | 2 | Slave-select behaviour between frames |
| ss_lead | input | 1 | Slave-select lead of half or one SCLK period |
| rx_delay | input | 2 | MISO capture delay in system clocks |
| tx_data | input | 16 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full (status only) |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_data | output | 16 | Received word |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty (status only) |
| rx_full | input | 1 | Receive FIFO full |
| rx_overflow | output | 1 | Sticky lost-frame flag |
| status | output | 5 | Busy and FIFO flags |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench sweeps every combination of polarity, phase, bit order, all four frame-size codes and all four transfer modes. Slave-select mode, lead and capture delay are rotated across those runs. Each run has three queued frames, with distinct transmit words and distinct slave reply words computed from the run index. A model slave, driven only by the pins, captures MOSI and answers on MISO. A mismatch in its captured words separates a phase or bit-order fault from a frame-length fault. The reply words pushed back, and their count, separate receive-path faults from direction-mode faults.

Cycle counts measured from the `ss_n` edges to the first SCLK edge, and across the high gaps, check the lead and spacing settings. Extra runs at the fastest and odd half-periods check the capture delay against a short half-period. A run with the receive FIFO full, followed by a normal run, shows that a lost frame sets the flag only in a receiving mode and that the flag stays set.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       frame_size,
  input  logic             cpha,
  input  logic             cpol,
  input  logic             lsb_first,
  input  logic [1:0]       xfer_mode,
  input  logic [1:0]       ss_mode,
  input  logic             ss_lead,
  input  logic [1:0]       rx_delay,
  input  logic [15:0]      tx_data,
  input  logic             tx_empty,
  input  logic             tx_full,
  output logic             tx_pop,
  output logic [15:0]      rx_data,
  output logic             rx_push,
  input  logic             rx_empty,
  input  logic             rx_full,
  output logic             rx_overflow,
  output logic [4:0]       status,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n
);
  localparam int HW = DIV_W - 1;

  typedef enum logic [2:0] {IDLE, LEAD, XFER, TAIL, GAP} state_t;

  state_t        st;
  logic [HW-1:0] hcnt, half_m1;
  logic [4:0]    nbits, rcnt;
  logic [5:0]    edges, edge_no;
  logic [15:0]   tx_sr, rx_sr, rx_next;
  logic [2:0]    dly;
  logic [1:0]    gap_halves;
  logic          sclk_r, gap_n, rx_done;
  logic          half_done, samp_edge, shift_edge, samp_now, cap;
  logic          frame_ok, gap_last, start;

  assign half_m1    = (baud_div[DIV_W-1:1] == '0) ? '0 : baud_div[DIV_W-1:1] - 1'b1;
  assign half_done  = hcnt == half_m1;
  assign nbits      = (frame_size == 2'd0) ? 5'd4 : (frame_size == 2'd1) ? 5'd8 : 5'd16;
  assign edge_no    = edges + 6'd1;
  assign samp_edge  = edge_no[0] ^ cpha;
  assign shift_edge = !samp_edge && !(cpha && edge_no == 6'd1);
  assign samp_now   = (st == XFER) && half_done && samp_edge;
  assign cap        = (rx_delay == 2'd0) ? samp_now : dly[rx_delay - 2'd1];
  assign gap_halves = (ss_mode == 2'd1) ? 2'd1 : (ss_mode == 2'd2) ? 2'd2 : 2'd0;
  assign gap_last   = gap_n == (gap_halves == 2'd2);
  assign frame_ok   = (st == TAIL) && half_done && rx_done;
  assign start      = !tx_empty && ((st == IDLE) || (frame_ok && gap_halves == 2'd0) ||
                                    ((st == GAP) && half_done && gap_last));
  assign rx_next    = lsb_first ? ((rx_sr >> 1) | (16'(miso) << (nbits - 5'd1)))
                                : {rx_sr[14:0], miso};

  assign tx_pop = start;
  assign sclk   = sclk_r ^ cpol;
  assign mosi   = !ss_n && (lsb_first ? tx_sr[0] : tx_sr[nbits - 5'd1]);
  assign status = {rx_full, rx_empty, tx_empty, tx_full, st != IDLE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      hcnt   <= '0;
      edges  <= '0;
      sclk_r <= 1'b0;
      ss_n   <= 1'b1;
      tx_sr  <= '0;
      gap_n  <= 1'b0;
    end else if (start) begin
      tx_sr <= (xfer_mode == 2'd2) ? '0 : tx_data;
      edges <= '0;
      hcnt  <= '0;
      ss_n  <= 1'b0;
      st    <= (ss_n && ss_lead) ? LEAD : XFER;
    end else begin
      case (st)
        IDLE: hcnt <= '0;
        LEAD:
          if (half_done) begin
            hcnt <= '0;
            st   <= XFER;
          end else hcnt <= hcnt + 1'b1;
        XFER:
          if (half_done) begin
            hcnt   <= '0;
            edges  <= edge_no;
            sclk_r <= ~sclk_r;
            if (shift_edge) tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
            if (edge_no == {nbits, 1'b0}) st <= TAIL;
          end else hcnt <= hcnt + 1'b1;
        TAIL:
          if (!half_done) hcnt <= hcnt + 1'b1;
          else if (rx_done) begin
            hcnt  <= '0;
            ss_n  <= 1'b1;
            gap_n <= 1'b0;
            st    <= (tx_empty || gap_halves == 2'd0) ? IDLE : GAP;
          end
        GAP:
          if (half_done) begin
            hcnt <= '0;
            if (gap_last) st <= IDLE;
            else gap_n <= 1'b1;
          end else hcnt <= hcnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly         <= '0;
      rx_sr       <= '0;
      rx_data     <= '0;
      rcnt        <= '0;
      rx_done     <= 1'b1;
      rx_push     <= 1'b0;
      rx_overflow <= 1'b0;
    end else begin
      dly     <= {dly[1:0], samp_now};
      rx_push <= 1'b0;
      if (start) begin
        rx_sr   <= '0;
        rcnt    <= '0;
        rx_done <= 1'b0;
      end else if (cap && !rx_done) begin
        if (rcnt == nbits - 5'd1) begin
          rx_data <= rx_next;
          rx_done <= 1'b1;
          rcnt    <= '0;
          if (xfer_mode != 2'd1) begin
            rx_push     <= !rx_full;
            rx_overflow <= rx_overflow | rx_full;
          end
        end else begin
          rx_sr <= rx_next;
          rcnt  <= rcnt + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpol,
  input logic [1:0] xfer_mode,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       rx_full,
  input logic       rx_overflow,
  input logic [4:0] status,
  input logic       sclk,
  input logic       ss_n
);
  // R10
  ss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !ss_n |-> status[0]);
  // R2
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n) !status[0] |-> sclk == cpol);
  // R12
  pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty);
  // R12
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> !tx_pop);
  // R5
  txonly_push_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> xfer_mode != 2'd1);
  // R11
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !$past(rx_full));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_overflow |=> rx_overflow);
endmodule

bind spi_frame_engine spi_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .xfer_mode(xfer_mode), .tx_empty(tx_empty),
  .tx_pop(tx_pop), .rx_push(rx_push), .rx_full(rx_full), .rx_overflow(rx_overflow),
  .status(status), .sclk(sclk), .ss_n(ss_n)
);

// File: tb/tb_spi_frame_engine.sv
`timescale 1ns/1ps
module tb_spi_frame_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] baud_div = 16'd8;
  logic [1:0] frame_size = 0, xfer_mode = 0, ss_mode = 0, rx_delay = 0;
  logic cpha = 0, cpol = 0, lsb_first = 0, ss_lead = 0;
  logic tx_full_r = 0, rx_empty = 1, rx_full = 0, miso = 0;
  logic tx_pop, rx_push, rx_overflow, sclk, mosi, ss_n, tx_empty;
  logic [15:0] tx_data, rx_data;
  logic [4:0] status;

  always #2 clk = ~clk;

  logic [15:0] tx_q [0:7];
  logic [15:0] rx_got [0:7];
  logic [15:0] mosi_got [0:7];
  int rd = 0, wr = 0, n_push = 0, fr_total = 0, sbit = 0, ec = 0;
  int hi_cnt = 0, t_fall = 0, n_fall = 0, lead_bad = 0, gap_bad = 0;
  int exp_lead = 0, exp_gap = 0, nb = 4, seed = 0;
  int n_chk = 0, n_bad = 0;
  bit pop_pend = 0, wait_first = 0, ss_prev = 1, sclk_prev = 0, const_ones = 0;

  assign tx_empty = (rd == wr);
  assign tx_data  = tx_q[rd[2:0]];

  spi_frame_engine dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .frame_size(frame_size), .cpha(cpha),
    .cpol(cpol), .lsb_first(lsb_first), .xfer_mode(xfer_mode), .ss_mode(ss_mode),
    .ss_lead(ss_lead), .rx_delay(rx_delay), .tx_data(tx_data), .tx_empty(tx_empty),
    .tx_full(tx_full_r), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_overflow(rx_overflow), .status(status),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  function automatic logic [15:0] slave_word(int f);
    return const_ones ? 16'hFFFF : 16'(seed * 16'h0135 + f * 16'h2C9B + 16'h4D21);
  endfunction

  function automatic logic [15:0] tx_word(int s, int f);
    return 16'((s * 16'h0777) ^ (f * 16'h05A3 + 16'h09E1));
  endfunction

  function automatic logic slave_bit(int f, int b);
    logic [15:0] w = slave_word(f);
    return lsb_first ? w[b] : w[nb - 1 - b];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model slave and FIFO side, all at the falling edge
  always @(negedge clk) begin
    if (pop_pend) rd++;
    pop_pend = tx_pop;
    if (rx_push && n_push < 8) begin
      rx_got[n_push] = rx_data;
      n_push++;
    end
    if (ss_n) begin
      if (!ss_prev) hi_cnt = 0;
      hi_cnt++;
      ec = 0;
      miso = slave_bit(fr_total, 0);
    end else begin
      if (ss_prev) begin
        n_fall++;
        if (fr_total > 0 && hi_cnt != exp_gap) gap_bad++;
        t_fall = 0;
        wait_first = 1;
      end else t_fall++;
      if (sclk != sclk_prev) begin
        ec++;
        if (wait_first) begin
          if (t_fall != exp_lead) lead_bad++;
          wait_first = 0;
        end
        if (((ec % 2) == 1) == (cpha == 0)) begin
          if (fr_total < 8) mosi_got[fr_total][lsb_first ? sbit : nb - 1 - sbit] = mosi;
          sbit++;
          if (sbit == nb) begin
            sbit = 0;
            fr_total++;
          end
        end else miso = slave_bit(fr_total, sbit);
      end
    end
    ss_prev = ss_n;
    sclk_prev = sclk;
  end

  task automatic run(input bit cp, input bit ph, input bit lsb, input int fs, input int md,
                     input int gm, input bit ld, input int dl, input int dv, input int n,
                     input bit ful, input int s);
    int guard;
    int gh;
    logic [15:0] mask;
    @(negedge clk);
    cpol = cp; cpha = ph; lsb_first = lsb; frame_size = 2'(fs); xfer_mode = 2'(md);
    ss_mode = 2'(gm); ss_lead = ld; rx_delay = 2'(dl); baud_div = 16'(dv); rx_full = ful;
    seed = s;
    nb = (fs == 0) ? 4 : (fs == 1) ? 8 : 16;
    mask = 16'((32'd1 << nb) - 1);
    gh = (gm == 1) ? 1 : (gm == 2) ? 2 : 0;
    exp_lead = (ld ? 2 : 1) * (dv / 2);
    exp_gap = gh * (dv / 2);
    fr_total = 0; sbit = 0; n_push = 0; n_fall = 0; lead_bad = 0; gap_bad = 0;
    for (int f = 0; f < 8; f++) begin
      mosi_got[f] = 16'h0;
      rx_got[f] = 16'h0;
    end
    rd = 0;
    for (int f = 0; f < n; f++) tx_q[f] = tx_word(s, f);
    @(negedge clk);
    wr = n;
    guard = 0;
    while ((rd != wr || status[0] || pop_pend) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) chk(0, "R10 watchdog", guard, 0);
    repeat (3) @(negedge clk);
    chk(rd == n, "R12 pops per frame", rd, n);
    chk(n_push == ((md == 1 || ful) ? 0 : n), "R5/R11 push count", n_push, (md == 1 || ful) ? 0 : n);
    for (int f = 0; f < n; f++) begin
      logic [15:0] em = (md == 2) ? 16'h0 : (tx_word(s, f) & mask);
      chk(mosi_got[f] == em, "R1/R3/R4/R5 mosi word", mosi_got[f], em);
      if (md != 1 && !ful)
        chk(rx_got[f] == (slave_word(f) & mask), "R1/R3/R4/R8 rx word", rx_got[f],
            slave_word(f) & mask);
    end
    chk(lead_bad == 0, "R7 lead cycles", lead_bad, 0);
    chk(gap_bad == 0, "R6 gap cycles", gap_bad, 0);
    chk(n_fall == (gh == 0 ? 1 : n), "R6 select falls", n_fall, gh == 0 ? 1 : n);
    chk(sclk == cp && ss_n && !status[0], "R2/R10 idle state", {sclk, ss_n, status[0]}, {cp, 2'b10});
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "R10 global watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 5'b01100 && ss_n && sclk == cpol && !tx_pop && !rx_overflow,
        "R9/R10 reset state", {status, ss_n, rx_overflow}, {5'b01100, 2'b10});
    rx_full = 1; rx_empty = 0; tx_full_r = 0;
    @(negedge clk);
    chk(status == 5'b10100, "R9 status map A", status, 5'b10100);
    rx_full = 0; rx_empty = 1; tx_full_r = 1;
    @(negedge clk);
    chk(status == 5'b01110, "R9 status map B", status, 5'b01110);
    tx_full_r = 0;
    idx = 0;
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int lb = 0; lb < 2; lb++)
          for (int fs = 0; fs < 4; fs++)
            for (int md = 0; md < 4; md++) begin
              run(cp[0], ph[0], lb[0], fs, md, idx % 4, idx[2], (idx / 3) % 4, 8, 3, 0, idx);
              idx++;
            end
    run(0, 1, 0, 1, 0, 1, 1, 0, 2, 3, 0, 200);
    run(1, 0, 1, 2, 0, 2, 0, 2, 6, 2, 0, 201);
    const_ones = 1;
    run(0, 1, 1, 0, 0, 0, 0, 3, 2, 3, 0, 202);
    run(1, 1, 0, 1, 0, 1, 0, 3, 2, 2, 0, 203);
    const_ones = 0;
    run(0, 0, 0, 1, 1, 0, 0, 0, 4, 2, 1, 204);
    chk(!rx_overflow, "R5/R11 tx-only never overflows", rx_overflow, 0);
    run(0, 0, 0, 1, 0, 0, 0, 0, 4, 2, 1, 205);
    chk(rx_overflow, "R11 overflow set", rx_overflow, 1);
    run(0, 0, 0, 1, 0, 0, 0, 0, 4, 2, 0, 206);
    chk(rx_overflow, "R11 overflow sticky", rx_overflow, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule